// File: doc/BRIEF.md
# Video Min/Max ALU with Secondary Combine

This block computes the minimum or maximum of two 32-bit operands. Each operand is taken from a chosen byte, halfword or full word of its source. That field is then widened to 32 bits as a signed or an unsigned value. Operand B can come from a register source or from a 16-bit immediate.

The two operands may differ in signedness, and the min/max is still exact in that case. The result can be saturated according to the signedness of the destination. It is then combined with a third source C: it can be added to C, compared against C, or inserted into a byte or halfword field of C.

The datapath is a single combinational stage. A parameter can add one output register with a valid flag. Decoding of the instruction word and access to the register file are done outside the block.

Top module: `vmm_alu`

## Requirements
- R1: Select code `{sgn, fld[2:0]}`: fld 0..3 picks byte 0..3, fld 4 picks halfword 0 (bits 15:0), fld 5 picks halfword 1 (bits 31:16), and fld 6 or 7 picks the whole word. The picked field is right-aligned. It is then sign-extended when sgn=1 and zero-extended when sgn=0.
- R2: When `b_is_reg_i`=0, operand B is `src_b_i[15:0]`. It is sign-extended to 32 bits when `b_sel_i[3]`=1 and zero-extended when `b_sel_i[3]`=0.
- R3: When A and B have the same signedness, the min/max uses a compare of that signedness (`is_max_i`=1 selects max), and the result takes that signedness.
- R4: When A and B differ in signedness, the exact mathematical min/max is returned. A max result is treated as unsigned, and a min result is treated as signed.
- R5: With `sat_i`=1 and `dst_signed_i`=1, an unsigned min/max result above 0x7FFFFFFF becomes 0x7FFFFFFF.
- R6: With `sat_i`=1 and `dst_signed_i`=0, a signed negative min/max result becomes 0.
- R7: `sec_op_i`=1 adds C to the min/max result, with 32-bit wrap-around and no saturation. `sec_op_i`=0 passes the result through unchanged.
- R8: `sec_op_i`=2 returns the max with C and `sec_op_i`=3 returns the min with C. The compare is signed when `dst_signed_i`=1 and unsigned when it is 0.
- R9: The merge codes insert the low bits of the result into C and keep every other bit of C. The codes are: 4 writes the low 16 bits into C[31:16], 5 writes the low 16 bits into C[15:0], 6 writes the low 8 bits into C[7:0], and 7 writes the low 8 bits into C[23:16].
- R10: With PIPE=1, `result_o` and `valid_o` follow the inputs by one clock cycle. Reset clears both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input operation valid |
| src_a_i | input | 32 | Source A |
| src_b_i | input | 32 | Source B, or the immediate in bits 15:0 |
| src_c_i | input | 32 | Source C for the secondary operation |
| a_sel_i | input | 4 | Field select and sign for A |
| b_sel_i | input | 4 | Field select and sign for B |
| b_is_reg_i | input | 1 | 1: B from register, 0: 16-bit immediate |
| is_max_i | input | 1 | 1: maximum, 0: minimum |
| sat_i | input | 1 | Saturate toward the destination signedness |
| dst_signed_i | input | 1 | Destination is signed |
| sec_op_i | input | 3 | Secondary operation code |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Final result |

## Verification
The hardest cases are mixed signedness with an operand whose bit 31 is set. Examples are a signed word of -1 against an unsigned word of 5, and an unsigned 0x80000000 against a signed -1. In these cases a plain signed or unsigned compare gives the wrong answer. The bench drives them directly with full-word selects. It also chains them into saturation so that an unsigned max above 0x7FFFFFFF meets a signed destination. Every result is compared against a 64-bit signed reference model.

// File: rtl/vmm_pkg.sv
package vmm_pkg;
  localparam int DW = 32;

  typedef enum logic [2:0] {
    SEC_PASS    = 3'd0,
    SEC_ACC     = 3'd1,
    SEC_MAX     = 3'd2,
    SEC_MIN     = 3'd3,
    SEC_MRG_H16 = 3'd4,
    SEC_MRG_L16 = 3'd5,
    SEC_MRG_B0  = 3'd6,
    SEC_MRG_B2  = 3'd7
  } sec_op_e;
endpackage

// File: rtl/vmm_extend.sv
module vmm_extend
  import vmm_pkg::*;
(
  input  logic [DW-1:0] raw_i,
  input  logic [3:0]    sel_i,
  output logic [DW-1:0] val_o
);
  logic [7:0]  byte_f;
  logic [15:0] half_f;

  always_comb begin
    byte_f = raw_i[{sel_i[1:0], 3'b000} +: 8];
    half_f = raw_i[{sel_i[0], 4'b0000} +: 16];
    if (!sel_i[2])
      val_o = {{(DW-8){sel_i[3] & byte_f[7]}}, byte_f};
    else if (!sel_i[1])
      val_o = {{(DW-16){sel_i[3] & half_f[15]}}, half_f};
    else
      val_o = raw_i;
  end
endmodule

// File: rtl/vmm_minmax.sv
module vmm_minmax
  import vmm_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          a_signed_i,
  input  logic          b_signed_i,
  input  logic          is_max_i,
  input  logic          sat_i,
  input  logic          dst_signed_i,
  output logic [DW-1:0] raw_o,
  output logic          res_signed_o,
  output logic [DW-1:0] sat_o
);
  logic signed [DW:0] a_x, b_x;
  logic               a_lt_b;

  // one extra bit makes mixed-sign compares exact
  assign a_x    = {a_signed_i & a_i[DW-1], a_i};
  assign b_x    = {b_signed_i & b_i[DW-1], b_i};
  assign a_lt_b = a_x < b_x;

  always_comb begin
    if (is_max_i) raw_o = a_lt_b ? b_i : a_i;
    else          raw_o = a_lt_b ? a_i : b_i;
    res_signed_o = (a_signed_i == b_signed_i) ? a_signed_i : ~is_max_i;
    sat_o = raw_o;
    if (sat_i && raw_o[DW-1]) begin
      if (dst_signed_i && !res_signed_o)      sat_o = {1'b0, {(DW-1){1'b1}}};
      else if (!dst_signed_i && res_signed_o) sat_o = '0;
    end
  end
endmodule

// File: rtl/vmm_post.sv
module vmm_post
  import vmm_pkg::*;
(
  input  logic [DW-1:0] res_i,
  input  logic [DW-1:0] c_i,
  input  logic [2:0]    op_i,
  input  logic          dst_signed_i,
  output logic [DW-1:0] out_o
);
  logic r_lt_c;

  assign r_lt_c = dst_signed_i ? ($signed(res_i) < $signed(c_i)) : (res_i < c_i);

  always_comb begin
    out_o = c_i;
    unique case (sec_op_e'(op_i))
      SEC_PASS:    out_o = res_i;
      SEC_ACC:     out_o = res_i + c_i;
      SEC_MAX:     out_o = r_lt_c ? c_i : res_i;
      SEC_MIN:     out_o = r_lt_c ? res_i : c_i;
      SEC_MRG_H16: out_o[31:16] = res_i[15:0];
      SEC_MRG_L16: out_o[15:0]  = res_i[15:0];
      SEC_MRG_B0:  out_o[7:0]   = res_i[7:0];
      SEC_MRG_B2:  out_o[23:16] = res_i[7:0];
      default:     out_o = res_i;
    endcase
  end
endmodule

// File: rtl/vmm_alu.sv
module vmm_alu
  import vmm_pkg::*;
#(
  parameter bit PIPE = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] src_a_i,
  input  logic [DW-1:0] src_b_i,
  input  logic [DW-1:0] src_c_i,
  input  logic [3:0]    a_sel_i,
  input  logic [3:0]    b_sel_i,
  input  logic          b_is_reg_i,
  input  logic          is_max_i,
  input  logic          sat_i,
  input  logic          dst_signed_i,
  input  logic [2:0]    sec_op_i,
  output logic          valid_o,
  output logic [DW-1:0] result_o
);
  localparam int IMMW = 16;

  logic [DW-1:0] a_val, b_reg_val, b_imm_val, b_val;
  logic [DW-1:0] mm_raw, mm_sat, post_res;
  logic          mm_signed;

  vmm_extend u_ext_a (.raw_i(src_a_i), .sel_i(a_sel_i), .val_o(a_val));
  vmm_extend u_ext_b (.raw_i(src_b_i), .sel_i(b_sel_i), .val_o(b_reg_val));

  assign b_imm_val = {{(DW-IMMW){b_sel_i[3] & src_b_i[IMMW-1]}}, src_b_i[IMMW-1:0]};
  assign b_val     = b_is_reg_i ? b_reg_val : b_imm_val;

  vmm_minmax u_mm (
    .a_i(a_val), .b_i(b_val), .a_signed_i(a_sel_i[3]), .b_signed_i(b_sel_i[3]),
    .is_max_i(is_max_i), .sat_i(sat_i), .dst_signed_i(dst_signed_i),
    .raw_o(mm_raw), .res_signed_o(mm_signed), .sat_o(mm_sat)
  );

  vmm_post u_post (
    .res_i(mm_sat), .c_i(src_c_i), .op_i(sec_op_i),
    .dst_signed_i(dst_signed_i), .out_o(post_res)
  );

  generate
    if (PIPE) begin : g_pipe
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          valid_o  <= 1'b0;
          result_o <= '0;
        end else begin
          valid_o  <= valid_i;
          if (valid_i) result_o <= post_res;
        end
      end
      p_latency_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o == $past(valid_i));
    end else begin : g_comb
      assign valid_o  = valid_i;
      assign result_o = post_res;
    end
  endgenerate

  // min/max bound checks against both widened operands
  logic signed [DW:0] a_w, b_w, r_w;
  assign a_w = {a_sel_i[3] & a_val[DW-1], a_val};
  assign b_w = {b_sel_i[3] & b_val[DW-1], b_val};
  assign r_w = {mm_signed & mm_raw[DW-1], mm_raw};

  p_max_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_max_i |-> (r_w >= a_w) && (r_w >= b_w));
  p_min_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !is_max_i |-> (r_w <= a_w) && (r_w <= b_w));
  p_sat_to_signed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sat_i && dst_signed_i && !mm_signed |-> !mm_sat[DW-1]);
  p_sat_to_unsigned_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sat_i && !dst_signed_i && mm_signed |-> !mm_sat[DW-1]);
  p_merge_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sec_op_i == SEC_MRG_L16 |-> post_res[31:16] == src_c_i[31:16]);
endmodule

// File: tb/sim_vmm_alu.sv
`timescale 1ns/1ps
module sim_vmm_alu;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] src_a_i = '0, src_b_i = '0, src_c_i = '0;
  logic [3:0]  a_sel_i = '0, b_sel_i = '0;
  logic        b_is_reg_i = 1'b1, is_max_i = 1'b0, sat_i = 1'b0, dst_signed_i = 1'b0;
  logic [2:0]  sec_op_i = '0;
  logic        valid_o;
  logic [31:0] result_o;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  vmm_alu u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .src_c_i(src_c_i),
    .a_sel_i(a_sel_i), .b_sel_i(b_sel_i), .b_is_reg_i(b_is_reg_i),
    .is_max_i(is_max_i), .sat_i(sat_i), .dst_signed_i(dst_signed_i),
    .sec_op_i(sec_op_i), .valid_o(valid_o), .result_o(result_o)
  );

  function automatic longint widen(input logic [31:0] raw, input logic [3:0] sel);
    int w, sh;
    longint u;
    if (!sel[2])      begin w = 8;  sh = 8 * int'(sel[1:0]); end
    else if (!sel[1]) begin w = 16; sh = 16 * int'(sel[0]);  end
    else              begin w = 32; sh = 0; end
    u = (longint'({32'd0, raw}) >>> sh) & ((64'sd1 <<< w) - 1);
    if (sel[3] && ((u >>> (w - 1)) & 1) == 1) u = u - (64'sd1 <<< w);
    return u;
  endfunction

  function automatic logic [31:0] model(
    input logic [31:0] a, b, c, input logic [3:0] asel, bsel,
    input logic breg, mx, st, ds, input logic [2:0] op);
    longint av, bv, rv, cv, r2;
    logic   rs;
    logic [31:0] r32, o;
    av = widen(a, asel);
    if (breg) bv = widen(b, bsel);
    else begin
      bv = longint'({48'd0, b[15:0]});
      if (bsel[3] && b[15]) bv = bv - 65536;
    end
    rv = mx ? ((av > bv) ? av : bv) : ((av < bv) ? av : bv);
    rs = (asel[3] == bsel[3]) ? asel[3] : !mx;
    if (st && ds && !rs && rv > 64'sh7FFFFFFF) rv = 64'sh7FFFFFFF;
    if (st && !ds && rs && rv < 0) rv = 0;
    r32 = rv[31:0];
    if (ds) begin
      r2 = longint'($signed(r32)); cv = longint'($signed(c));
    end else begin
      r2 = longint'({32'd0, r32}); cv = longint'({32'd0, c});
    end
    o = c;
    case (op)
      3'd0: o = r32;
      3'd1: o = r32 + c;
      3'd2: o = (r2 > cv) ? r32 : c;
      3'd3: o = (r2 < cv) ? r32 : c;
      3'd4: o[31:16] = r32[15:0];
      3'd5: o[15:0]  = r32[15:0];
      3'd6: o[7:0]   = r32[7:0];
      default: o[23:16] = r32[7:0];
    endcase
    return o;
  endfunction

  task automatic run(input string tag, input logic [31:0] a, b, c,
                     input logic [3:0] asel, bsel, input logic breg, mx, st, ds,
                     input logic [2:0] op);
    logic [31:0] exp;
    exp = model(a, b, c, asel, bsel, breg, mx, st, ds, op);
    @(negedge clk);
    src_a_i = a; src_b_i = b; src_c_i = c; a_sel_i = asel; b_sel_i = bsel;
    b_is_reg_i = breg; is_max_i = mx; sat_i = st; dst_signed_i = ds; sec_op_i = op;
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    n_chk++;
    if (result_o !== exp || valid_o !== 1'b1) begin
      n_fail++;
      $display("FAIL %s: result=%h valid=%b expected=%h valid=1", tag, result_o, valid_o, exp);
    end
  endtask

  task automatic t_reset;
    n_chk++;
    if (valid_o !== 1'b0 || result_o !== 32'h0) begin
      n_fail++;
      $display("FAIL R10 reset: valid=%b result=%h expected valid=0 result=0", valid_o, result_o);
    end
  endtask

  task automatic t_extend;  // R1
    run("R1 byte2 signed",  32'h0080_0000, 32'h0, 0, 4'b1010, 4'b1110, 1, 0, 0, 1, 0);
    run("R1 byte3 unsigned",32'hF100_0000, 32'h10, 0, 4'b0011, 4'b0110, 1, 1, 0, 0, 0);
    run("R1 half1 signed",  32'h8001_1234, 32'h0, 0, 4'b1101, 4'b1110, 1, 0, 0, 1, 0);
    run("R1 half0 unsigned",32'h0000_FFFE, 32'h1, 0, 4'b0100, 4'b0110, 1, 1, 0, 0, 0);
  endtask

  task automatic t_imm;  // R2
    run("R2 imm signed",   32'hFFFF_FFFE, 32'hABCD_FFFF, 0, 4'b1110, 4'b1110, 0, 1, 0, 1, 0);
    run("R2 imm unsigned", 32'h0000_0005, 32'hABCD_FFFF, 0, 4'b0110, 4'b0110, 0, 1, 0, 0, 0);
  endtask

  task automatic t_same;  // R3
    run("R3 signed min",   32'hFFFF_FFFB, 32'h3, 0, 4'b1110, 4'b1110, 1, 0, 0, 1, 0);
    run("R3 unsigned max", 32'hFFFF_FFF0, 32'h3, 0, 4'b0110, 4'b0110, 1, 1, 0, 0, 0);
    run("R3 unsigned min", 32'hFFFF_FFF0, 32'h3, 0, 4'b0110, 4'b0110, 1, 0, 0, 0, 0);
  endtask

  task automatic t_mixed;  // R4
    run("R4 max s-1 vs u5",    32'hFFFF_FFFF, 32'h5, 0, 4'b1110, 4'b0110, 1, 1, 0, 0, 0);
    run("R4 min u8000 vs s-1", 32'h8000_0000, 32'hFFFF_FFFF, 0, 4'b0110, 4'b1110, 1, 0, 0, 1, 0);
    run("R4 max s7 vs u9000",  32'h0000_0007, 32'h9000_0000, 0, 4'b1110, 4'b0110, 1, 1, 0, 0, 0);
    run("R4 min sbyte vs uword", 32'h0000_00FF, 32'hF000_0000, 0, 4'b1000, 4'b0110, 1, 0, 0, 1, 0);
  endtask

  task automatic t_sat;
    run("R5 clamp to 7fffffff", 32'h0000_0007, 32'h9000_0000, 0, 4'b1110, 4'b0110, 1, 1, 1, 1, 0);
    run("R5 no clamp small",    32'h0000_0007, 32'h0000_0009, 0, 4'b1110, 4'b0110, 1, 1, 1, 1, 0);
    run("R6 clamp neg to 0",    32'hFFFF_FFF9, 32'h4, 0, 4'b1110, 4'b1110, 1, 0, 1, 0, 0);
    run("R6 sat off keeps neg", 32'hFFFF_FFF9, 32'h4, 0, 4'b1110, 4'b1110, 1, 0, 0, 0, 0);
  endtask

  task automatic t_sec;
    run("R7 acc wrap",      32'hFFFF_FFFF, 32'h0, 32'h2, 4'b0110, 4'b0110, 1, 1, 0, 0, 3'd1);
    run("R7 pass",          32'h1234_5678, 32'h0, 32'h2, 4'b0110, 4'b0110, 1, 1, 0, 0, 3'd0);
    run("R8 max C signed",  32'h0000_0003, 32'h1, 32'hFFFF_FFF0, 4'b0110, 4'b0110, 1, 1, 0, 1, 3'd2);
    run("R8 max C unsigned",32'h0000_0003, 32'h1, 32'hFFFF_FFF0, 4'b0110, 4'b0110, 1, 1, 0, 0, 3'd2);
    run("R8 min C signed",  32'h0000_0003, 32'h1, 32'hFFFF_FFF0, 4'b0110, 4'b0110, 1, 1, 0, 1, 3'd3);
    run("R8 min C unsigned",32'h0000_0003, 32'h1, 32'hFFFF_FFF0, 4'b0110, 4'b0110, 1, 1, 0, 0, 3'd3);
    run("R9 merge hi16",    32'h0000_BEEF, 32'h0, 32'h1122_3344, 4'b0110, 4'b0110, 1, 1, 0, 0, 3'd4);
    run("R9 merge lo16",    32'h0000_BEEF, 32'h0, 32'h1122_3344, 4'b0110, 4'b0110, 1, 1, 0, 0, 3'd5);
    run("R9 merge b0",      32'h0000_BEEF, 32'h0, 32'h1122_3344, 4'b0110, 4'b0110, 1, 1, 0, 0, 3'd6);
    run("R9 merge b2",      32'h0000_BEEF, 32'h0, 32'h1122_3344, 4'b0110, 4'b0110, 1, 1, 0, 0, 3'd7);
  endtask

  task automatic t_valid;  // R10
    @(negedge clk);
    n_chk++;
    if (valid_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 valid drop: valid=%b expected=0", valid_o);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_extend();
    t_imm();
    t_same();
    t_mixed();
    t_sat();
    t_sec();
    t_valid();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule